// File: doc/BRIEF.md
# Coin-Operated Drink Dispenser Controller

This block sequences a drink dispenser. It counts two 25-cent coins and then waits for one of three product buttons. It fires a single-cycle dispense strobe for the chosen product and waits until the customer removes the bottle. After that it goes back to waiting for money. The coin slot is enabled only while the controller is collecting money. Button presses and coins that arrive at other times are dropped.

A separate fault path handles a jammed bottle. A jam level from the mechanism overrides every operating state. The controller enters a locked-out state that takes no coins and releases no product. Any credit held at that moment is lost. A jam-cleared pulse sends the controller back to waiting for money with zero credit. All inputs other than the jam level are treated as single-cycle pulses sampled on the rising clock edge.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the waiting-for-money state with zero credit, so coin_en_o is 1, jam_o is 0 and all dispense strobes are 0.
- R2: A coin pulse while waiting for money gives 25 cents of credit. A second coin gives 50 cents and the paid state. coin_en_o is 1 only at zero credit and at 25 cents.
- R3: Product buttons pressed before 50 cents is collected produce no strobe and leave the credit unchanged.
- R4: A product button in the paid state makes the matching dispense strobe 1 for exactly one cycle. The strobe appears on the clock edge that samples the button. At most one strobe is ever 1.
- R5: When several buttons are pressed in the same cycle, the product priority is cola first, then diet cola, then lemon-lime.
- R6: After a dispense, the controller waits for the bottle-taken pulse and then returns to waiting for money. A bottle-taken pulse in any other state has no effect.
- R7: Coin pulses in the paid, dispensing or jammed states are ignored and add no credit.
- R8: jam_i high in any state other than jammed moves the controller to the jammed state on that edge. jam_o becomes 1, and this takes precedence over any other input in the same cycle.
- R9: While jammed, coin_en_o is 0, no dispense strobe is issued, and coin, button and bottle-taken pulses have no effect.
- R10: A jam-cleared pulse in the jammed state returns the controller to waiting for money with zero credit. Credit held before the jam is discarded. A jam-cleared pulse outside the jammed state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_i | input | 1 | Pulse: one 25-cent coin inserted |
| btn_cola_i | input | 1 | Pulse: cola button |
| btn_diet_i | input | 1 | Pulse: diet cola button |
| btn_lime_i | input | 1 | Pulse: lemon-lime button |
| taken_i | input | 1 | Pulse: bottle removed from the tray |
| jam_i | input | 1 | Level: bottle stuck in the mechanism |
| jam_clr_i | input | 1 | Pulse: jam has been cleared |
| disp_cola_o | output | 1 | One-cycle strobe: release cola |
| disp_diet_o | output | 1 | One-cycle strobe: release diet cola |
| disp_lime_o | output | 1 | One-cycle strobe: release lemon-lime |
| coin_en_o | output | 1 | Coin slot enabled |
| jam_o | output | 1 | Jammed, lockout active |

## Verification
Every result is due on the first rising edge that samples the stimulus. coin_en_o and jam_o are decoded from the state register, and the dispense strobes come from a register loaded on that same edge. The bench drives each stimulus on a falling edge and waits for the next rising edge. It compares all five outputs 1 ns later, then clears the inputs on the following falling edge. This means every dispense strobe is seen in its only valid cycle, and a strobe that stayed high is caught at the next step. Credit is never visible directly, so ignored coins and discarded credit are checked by counting how many further coins it takes for coin_en_o to drop.

// File: rtl/vend_pkg.sv
package vend_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_Q25  = 3'd1,
        ST_PAID = 3'd2,
        ST_DISP = 3'd3,
        ST_JAM  = 3'd4
    } vstate_t;

    localparam int unsigned NUM_PROD = 3;

    typedef enum logic [1:0] {
        PR_NONE = 2'd0,
        PR_COLA = 2'd1,
        PR_DIET = 2'd2,
        PR_LIME = 2'd3
    } prod_t;

    // Fixed priority: cola, then diet, then lemon-lime.
    function automatic prod_t pick_prod(input logic cola, input logic diet, input logic lime);
        if (cola)      return PR_COLA;
        else if (diet) return PR_DIET;
        else if (lime) return PR_LIME;
        else           return PR_NONE;
    endfunction

    function automatic logic [NUM_PROD-1:0] prod_onehot(input prod_t p);
        logic [NUM_PROD-1:0] v;
        v = '0;
        if (p != PR_NONE) v[int'(p) - 1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/vend_select.sv
module vend_select
    import vend_pkg::*;
(
    input  logic  btn_cola,
    input  logic  btn_diet,
    input  logic  btn_lime,
    output prod_t choice
);
    always_comb choice = pick_prod(btn_cola, btn_diet, btn_lime);
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                coin,
    input  prod_t               choice,
    input  logic                taken,
    input  logic                jam,
    input  logic                jam_clr,
    output vstate_t             state,
    output logic [NUM_PROD-1:0] strobe
);
    vstate_t nxt;

    always_comb begin
        nxt = state;
        if (jam && state != ST_JAM) begin
            nxt = ST_JAM;
        end else begin
            unique case (state)
                ST_IDLE: if (coin) nxt = ST_Q25;
                ST_Q25:  if (coin) nxt = ST_PAID;
                ST_PAID: if (choice != PR_NONE) nxt = ST_DISP;
                ST_DISP: if (taken) nxt = ST_IDLE;
                ST_JAM:  if (jam_clr) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            strobe <= '0;
        end else begin
            state  <= nxt;
            strobe <= (state == ST_PAID && !jam) ? prod_onehot(choice) : '0;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) rst |=> state == ST_IDLE);
    assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (rst) $onehot0(strobe));
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst) (|strobe) |=> strobe == '0);
    assert_strobe_from_paid_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_PAID) |=> strobe == '0);
    assert_jam_enters_R8: assert property (@(posedge clk) disable iff (rst)
        (jam && state != ST_JAM) |=> state == ST_JAM);
    assert_jam_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JAM) |=> strobe == '0);
    assert_jam_exit_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JAM && jam_clr) |=> state == ST_IDLE);
    assert_disp_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DISP && !taken && !jam) |=> state == ST_DISP);
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic coin_i,
    input  logic btn_cola_i,
    input  logic btn_diet_i,
    input  logic btn_lime_i,
    input  logic taken_i,
    input  logic jam_i,
    input  logic jam_clr_i,
    output logic disp_cola_o,
    output logic disp_diet_o,
    output logic disp_lime_o,
    output logic coin_en_o,
    output logic jam_o
);
    prod_t               choice;
    vstate_t             state;
    logic [NUM_PROD-1:0] strobe;

    vend_select u_select (
        .btn_cola (btn_cola_i),
        .btn_diet (btn_diet_i),
        .btn_lime (btn_lime_i),
        .choice   (choice)
    );

    vend_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .coin    (coin_i),
        .choice  (choice),
        .taken   (taken_i),
        .jam     (jam_i),
        .jam_clr (jam_clr_i),
        .state   (state),
        .strobe  (strobe)
    );

    assign disp_cola_o = strobe[int'(PR_COLA) - 1];
    assign disp_diet_o = strobe[int'(PR_DIET) - 1];
    assign disp_lime_o = strobe[int'(PR_LIME) - 1];
    assign coin_en_o   = (state == ST_IDLE) || (state == ST_Q25);
    assign jam_o       = (state == ST_JAM);

    assert_slot_locked_R9: assert property (@(posedge clk) disable iff (rst) !(coin_en_o && jam_o));
    assert_slot_closed_after_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_Q25 && coin_i && !jam_i) |=> !coin_en_o);
endmodule

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coin_i = 0, btn_cola_i = 0, btn_diet_i = 0, btn_lime_i = 0;
    logic taken_i = 0, jam_i = 0, jam_clr_i = 0;
    logic disp_cola_o, disp_diet_o, disp_lime_o, coin_en_o, jam_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vend_ctrl u_dut (
        .clk(clk), .rst(rst), .coin_i(coin_i),
        .btn_cola_i(btn_cola_i), .btn_diet_i(btn_diet_i), .btn_lime_i(btn_lime_i),
        .taken_i(taken_i), .jam_i(jam_i), .jam_clr_i(jam_clr_i),
        .disp_cola_o(disp_cola_o), .disp_diet_o(disp_diet_o), .disp_lime_o(disp_lime_o),
        .coin_en_o(coin_en_o), .jam_o(jam_o)
    );

    // Vector: [15:12] requirement, [11:5] inputs {coin,cola,diet,lime,taken,jam,clr},
    //         [4:0] expected {cola,diet,lime,coin_en,jam}
    localparam int NV = 29;
    localparam logic [15:0] VEC [NV] = '{
        {4'd1,  7'b0000000, 5'b00010},
        {4'd3,  7'b0100000, 5'b00010},
        {4'd2,  7'b1000000, 5'b00010},
        {4'd3,  7'b0010000, 5'b00010},
        {4'd2,  7'b1000000, 5'b00000},
        {4'd7,  7'b1000000, 5'b00000},
        {4'd5,  7'b0111000, 5'b10000},
        {4'd4,  7'b0000000, 5'b00000},
        {4'd7,  7'b1000000, 5'b00000},
        {4'd6,  7'b0000100, 5'b00010},
        {4'd2,  7'b1000000, 5'b00010},
        {4'd8,  7'b0000010, 5'b00001},
        {4'd9,  7'b1000010, 5'b00001},
        {4'd10, 7'b0000001, 5'b00010},
        {4'd10, 7'b1000000, 5'b00010},
        {4'd2,  7'b1000000, 5'b00000},
        {4'd5,  7'b0011000, 5'b01000},
        {4'd6,  7'b0000100, 5'b00010},
        {4'd2,  7'b1000000, 5'b00010},
        {4'd2,  7'b1000000, 5'b00000},
        {4'd4,  7'b0001000, 5'b00100},
        {4'd8,  7'b0000010, 5'b00001},
        {4'd9,  7'b0000110, 5'b00001},
        {4'd9,  7'b0100010, 5'b00001},
        {4'd10, 7'b0000001, 5'b00010},
        {4'd2,  7'b1000000, 5'b00010},
        {4'd2,  7'b1000000, 5'b00000},
        {4'd8,  7'b0100010, 5'b00001},
        {4'd10, 7'b0000001, 5'b00010}
    };

    function automatic string tag(input logic [3:0] n);
        case (n)
            4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
            4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
            4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input logic [4:0] exp, input string req);
        logic [4:0] act;
        act = {disp_cola_o, disp_diet_o, disp_lime_o, coin_en_o, jam_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs {cola,diet,lime,coin_en,jam} actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive inputs on a falling edge, sample 1 ns after the next rising edge, then clear.
    task automatic step(input logic [6:0] in, input logic [4:0] exp, input string req);
        @(negedge clk);
        {coin_i, btn_cola_i, btn_diet_i, btn_lime_i, taken_i, jam_i, jam_clr_i} = in;
        @(posedge clk);
        #1;
        check(exp, req);
        @(negedge clk);
        {coin_i, btn_cola_i, btn_diet_i, btn_lime_i, taken_i, jam_i, jam_clr_i} = '0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(5'b00010, "R1");
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][11:5], VEC[i][4:0], tag(VEC[i][15:12]));
        end
        // R10: jam-cleared pulse outside the jammed state has no effect (from 25 cents)
        step(7'b1000000, 5'b00010, "R10");
        step(7'b0000001, 5'b00010, "R10");
        step(7'b1000000, 5'b00000, "R10");
        // R6: bottle-taken in paid state ignored
        step(7'b0000100, 5'b00000, "R6");
        step(7'b0000000, 5'b00000, "R6");
        // R1: reset from paid clears credit
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(5'b00010, "R1");
        @(negedge clk);
        rst = 1'b0;
        step(7'b1000000, 5'b00010, "R1");
        step(7'b0000001, 5'b00010, "R10");
        step(7'b1000000, 5'b00000, "R2");
        // R4: lemon-lime alone, then strobe drops next cycle
        step(7'b0001000, 5'b00100, "R4");
        step(7'b0000000, 5'b00000, "R4");
        step(7'b0000100, 5'b00010, "R6");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule